// File: doc/BRIEF.md
# Temperature Conversion Mode Sequencer

This block decides when an external temperature converter is started and what becomes of its result. A small configuration register selects continuous conversion or shutdown, requests single conversions while shut down, and picks a resolution of 9 to 12 bits. Each conversion is timed by a cycle counter. The window is `BASE_TICKS` cycles at 9 bits and doubles with each added bit, so it stands in for real conversion times that also double per step.

The converter model receives a one-cycle start pulse. Some time later it returns a 12-bit raw reading with a one-cycle done strobe. A conversion ends once its window has elapsed and a reading has arrived, whichever comes last. At that point the reading is masked to the active resolution and stored as a 12-bit two's-complement temperature at 1/16 °C per LSB (25 °C is 0x190, −25 °C is 0xE70). A completion pulse then goes to the alert logic.

Top module: `tconv_seq`

## Requirements
- R1: With the halt bit clear, conversions run back to back: the start pulse of the next conversion appears in the same cycle as the completion pulse of the previous one, and `busy_o` stays high. An idle block with halt clear starts a conversion on the next cycle.
- R2: Setting the halt bit lets the conversion in progress finish and store its result. In the cycle of its completion pulse `busy_o` is low, and no further start pulse occurs while halt stays set.
- R3: A configuration write with the single bit (bit 3) set, made while idle and halted, starts exactly one conversion. The block then returns to idle.
- R4: A single-conversion request made while a conversion is in progress is ignored, even when halt is set. After the draining conversion no extra conversion starts.
- R5: The readback `cfg_rdata_o` holds halt in bit 0 and resolution in bits 2:1, as last written. Bit 3 (single) always reads 0.
- R6: A conversion's window is `BASE_TICKS << res` cycles (res 0..3 = 9..12 bits), measured from its start pulse to its completion pulse. The resolution is taken when the conversion starts, so a later write affects only the next conversion.
- R7: The stored result keeps the top 9, 10, 11 or 12 bits of the raw reading for res 00, 01, 10, 11, and the remaining low bits read 0.
- R8: After reset `temp_o` is 0 until the first completion pulse, and `busy_o`, `adc_start_o` and `conv_done_o` are low during reset.
- R9: `temp_o` changes only in a cycle where `conv_done_o` is high, with all 12 bits updated together.
- R10: `adc_start_o` and `conv_done_o` are one-cycle pulses. A reading that arrives after the window ends the conversion two cycles after its done strobe. A done strobe while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Write data: [0] halt, [2:1] resolution, [3] single request |
| cfg_rdata_o | output | 4 | Readback: [0] halt, [2:1] resolution, [3] always 0 |
| adc_done_i | input | 1 | Converter result strobe |
| adc_raw_i | input | 12 | Converter raw reading |
| adc_start_o | output | 1 | Conversion start pulse to the converter |
| busy_o | output | 1 | A conversion is in progress |
| temp_o | output | 12 | Stored two's-complement temperature |
| conv_done_o | output | 1 | Conversion complete pulse for alert logic |

## Verification
The hardest case to reach is a single-conversion request that arrives while halt is already set but the last conversion is still draining. Reaching it takes continuous mode, then a halt write early in a conversion, then the single request before that conversion ends. The bench then counts start pulses over a long idle stretch. It also drives a reading later than the window to stretch a conversion, and injects a stray done strobe while idle.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  localparam int TEMP_W    = 12;
  localparam int RES_W     = 2;
  localparam int RES_STEPS = 4;
  localparam int CFG_W     = 4;
  localparam int CFG_HALT  = 0;
  localparam int CFG_RES   = 1;
  localparam int CFG_SHOT  = 3;

  typedef enum logic {ST_IDLE, ST_CONV} seq_state_e;

  // keep the top 9+res bits of a 12-bit reading
  function automatic logic [TEMP_W-1:0] res_mask(input logic [RES_W-1:0] r);
    logic [RES_W-1:0] drop;
    drop = ~r;
    return {TEMP_W{1'b1}} << drop;
  endfunction
endpackage

// File: rtl/tconv_cfg_reg.sv
module tconv_cfg_reg
  import tconv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             halt_wd_i,
  input  logic [RES_W-1:0] res_wd_i,
  output logic             halt_o,
  output logic [RES_W-1:0] res_o,
  output logic [RES_W-1:0] res_nxt_o,
  output logic [CFG_W-1:0] rdata_o
);
  logic             halt_q, halt_d;
  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    halt_d = halt_q;
    res_d  = res_q;
    if (wr_i) begin
      halt_d = halt_wd_i;
      res_d  = res_wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      res_q  <= '0;
    end else if (wr_i) begin
      halt_q <= halt_d;
      res_q  <= res_d;
    end
  end

  assign halt_o    = halt_q;
  assign res_o     = res_q;
  assign res_nxt_o = res_d;
  assign rdata_o   = {1'b0, res_q, halt_q};
endmodule

// File: rtl/tconv_timer.sv
module tconv_timer
  import tconv_pkg::*;
#(
  parameter int BASE_TICKS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [RES_W-1:0] res_i,
  output logic             elapsed_o,
  output logic [RES_W-1:0] res_act_o
);
  localparam int MAX_WIN = BASE_TICKS << (RES_STEPS - 1);
  localparam int CNT_W   = $clog2(MAX_WIN + 1);

  logic [CNT_W-1:0] win_tab [RES_STEPS];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RES_W-1:0] res_q;
  logic             cnt_en;

  for (genvar g = 0; g < RES_STEPS; g++) begin : g_win
    assign win_tab[g] = CNT_W'(BASE_TICKS << g);
  end

  assign elapsed_o = (cnt_q >= (win_tab[res_q] - 1'b1));
  assign cnt_en    = clear_i | ~elapsed_o;
  assign cnt_d     = clear_i ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (clear_i) begin
      res_q <= res_i;
    end
  end

  assign res_act_o = res_q;
endmodule

// File: rtl/tconv_result.sv
module tconv_result
  import tconv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              busy_i,
  input  logic              sample_i,
  input  logic [TEMP_W-1:0] raw_i,
  input  logic              commit_i,
  input  logic [RES_W-1:0]  res_i,
  output logic              have_o,
  output logic [TEMP_W-1:0] temp_o
);
  logic              have_q, have_d, take;
  logic [TEMP_W-1:0] raw_q, temp_q;

  assign take = busy_i & sample_i & ~clear_i;

  always_comb begin
    have_d = have_q;
    if (clear_i)   have_d = 1'b0;
    else if (take) have_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) have_q <= 1'b0;
    else         have_q <= have_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   raw_q <= '0;
    else if (take) raw_q <= raw_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       temp_q <= '0;
    else if (commit_i) temp_q <= raw_q & res_mask(res_i);
  end

  assign have_o = have_q;
  assign temp_o = temp_q;
endmodule

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
  import tconv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic shot_i,
  input  logic elapsed_i,
  input  logic have_i,
  output logic start_o,
  output logic commit_o,
  output logic busy_o,
  output logic start_q_o,
  output logic done_q_o
);
  seq_state_e state_q, state_d;
  logic       start_q, done_q;

  always_comb begin
    state_d  = state_q;
    start_o  = 1'b0;
    commit_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!halt_i || shot_i) begin
          start_o = 1'b1;
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        if (elapsed_i && have_i) begin
          commit_o = 1'b1;
          if (!halt_i) start_o = 1'b1;
          else         state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_o;
      done_q  <= commit_o;
    end
  end

  assign busy_o    = (state_q == ST_CONV);
  assign start_q_o = start_q;
  assign done_q_o  = done_q;
endmodule

// File: rtl/tconv_seq.sv
module tconv_seq
  import tconv_pkg::*;
#(
  parameter int BASE_TICKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic              adc_done_i,
  input  logic [TEMP_W-1:0] adc_raw_i,
  output logic              adc_start_o,
  output logic              busy_o,
  output logic [TEMP_W-1:0] temp_o,
  output logic              conv_done_o
);
  logic             halt, shot, start, commit, elapsed, have, busy;
  logic [RES_W-1:0] res, res_nxt, res_act;

  tconv_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr_i),
    .halt_wd_i (cfg_wdata_i[CFG_HALT]),
    .res_wd_i  (cfg_wdata_i[CFG_RES +: RES_W]),
    .halt_o    (halt),
    .res_o     (res),
    .res_nxt_o (res_nxt),
    .rdata_o   (cfg_rdata_o)
  );

  // single request honoured only when halted and idle
  assign shot = cfg_wr_i & cfg_wdata_i[CFG_SHOT] & halt & ~busy;

  tconv_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt),
    .shot_i    (shot),
    .elapsed_i (elapsed),
    .have_i    (have),
    .start_o   (start),
    .commit_o  (commit),
    .busy_o    (busy),
    .start_q_o (adc_start_o),
    .done_q_o  (conv_done_o)
  );

  tconv_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start),
    .res_i     (res_nxt),
    .elapsed_o (elapsed),
    .res_act_o (res_act)
  );

  tconv_result u_result (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start),
    .busy_i   (busy),
    .sample_i (adc_done_i),
    .raw_i    (adc_raw_i),
    .commit_i (commit),
    .res_i    (res_act),
    .have_o   (have),
    .temp_o   (temp_o)
  );

  assign busy_o = busy;

  logic unused_res;
  assign unused_res = ^res;
endmodule

// File: rtl/tconv_seq_chk.sv
module tconv_seq_chk
  import tconv_pkg::*;
#(
  parameter int BASE_TICKS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic [CFG_W-1:0]  cfg_rdata_o,
  input logic              adc_start_o,
  input logic              busy_o,
  input logic [TEMP_W-1:0] temp_o,
  input logic              conv_done_o
);
  logic [15:0]      chk_cnt;
  logic [RES_W-1:0] chk_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt <= '0;
      chk_res <= '0;
    end else if (adc_start_o) begin
      chk_cnt <= 16'd1;
      chk_res <= cfg_rdata_o[CFG_RES +: RES_W];
    end else if (chk_cnt != 16'hFFFF) begin
      chk_cnt <= chk_cnt + 16'd1;
    end
  end

  // R1
  idle_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cfg_rdata_o[CFG_HALT]) |=> adc_start_o);
  // R2
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cfg_rdata_o[CFG_HALT] && !cfg_wr_i) |=> !adc_start_o);
  // R3
  shot_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_wdata_i[CFG_SHOT] && cfg_rdata_o[CFG_HALT] && !busy_o) |=> adc_start_o);
  // R5
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> (cfg_rdata_o[2:0] == $past(cfg_wdata_i[2:0])) && !cfg_rdata_o[CFG_SHOT]);
  // R6
  window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (int'(chk_cnt) >= (BASE_TICKS << chk_res)));
  // R7
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> ((temp_o & ~res_mask(chk_res)) == '0));
  // R9
  temp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_o |-> $stable(temp_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |=> !conv_done_o);
  // R10
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);
endmodule

bind tconv_seq tconv_seq_chk #(.BASE_TICKS(BASE_TICKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .adc_start_o (adc_start_o),
  .busy_o      (busy_o),
  .temp_o      (temp_o),
  .conv_done_o (conv_done_o)
);

// File: tb/tconv_seq_bench.sv
module tconv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [3:0]  cfg_wdata_i = '0;
  logic [3:0]  cfg_rdata_o;
  logic        adc_done_i = 1'b0;
  logic [11:0] adc_raw_i = '0;
  logic        adc_start_o, busy_o, conv_done_o;
  logic [11:0] temp_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, cur_start = 0, last_win = 0, done_cnt = 0, start_cnt = 0, glitch = 0;
  logic [11:0] prev_temp = '0;
  int model_lat = 3;
  logic [11:0] model_raw = 12'h193;
  bit inj = 1'b0;
  logic [11:0] inj_raw = '0;

  tconv_seq #(.BASE_TICKS(BASE)) u_tconv_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .adc_done_i(adc_done_i), .adc_raw_i(adc_raw_i),
    .adc_start_o(adc_start_o), .busy_o(busy_o), .temp_o(temp_o), .conv_done_o(conv_done_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // converter model
  initial begin
    int lat_cnt;
    lat_cnt = 0;
    forever begin
      @(negedge clk_i);
      adc_done_i = 1'b0;
      if (adc_start_o) begin
        lat_cnt = model_lat;
      end else if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          adc_done_i = 1'b1;
          adc_raw_i  = model_raw;
        end
      end else if (inj) begin
        adc_done_i = 1'b1;
        adc_raw_i  = inj_raw;
        inj = 1'b0;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (conv_done_o) begin
        last_win = cyc - cur_start;
        done_cnt++;
      end
      if (adc_start_o) begin
        cur_start = cyc;
        start_cnt++;
      end
      if (rst_ni && (temp_o != prev_temp) && !conv_done_o) glitch++;
      prev_temp = temp_o;
    end
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic write_cfg(input bit shot, input logic [1:0] res, input bit halt);
    cfg_wdata_i = {shot, res, halt};
    cfg_wr_i = 1'b1;
    tick(1);
    cfg_wr_i = 1'b0;
  endtask

  task automatic wait_done();
    int prev;
    prev = done_cnt;
    for (int i = 0; i < 2000; i++) begin
      if (done_cnt != prev) break;
      tick(1);
    end
  endtask

  task automatic t_reset();
    tick(3);
    chk_eq("R8 temp in reset", temp_o, 0);
    chk_eq("R8 busy in reset", busy_o, 0);
    chk_eq("R8 pulses in reset", {adc_start_o, conv_done_o}, 0);
    rst_ni = 1'b1;
    tick(4);
    chk_eq("R8 temp before first result", temp_o, 0);
    chk_eq("R1 busy after reset", busy_o, 1);
    wait_done();
    chk_eq("R7 9-bit result of 0x193", temp_o, 12'h190);
    chk_eq("R6 9-bit window", last_win, BASE);
  endtask

  task automatic t_continuous();
    wait_done();
    chk_eq("R1 restart with done", adc_start_o, 1);
    chk_eq("R1 busy held", busy_o, 1);
    chk_eq("R6 back-to-back window", last_win, BASE);
  endtask

  task automatic t_resolution();
    write_cfg(1'b0, 2'b11, 1'b0);
    model_raw = 12'hE71;
    wait_done();
    chk_eq("R6 old res kept", last_win, BASE);
    chk_eq("R7 9-bit of 0xE71", temp_o, 12'hE70);
    wait_done();
    chk_eq("R6 12-bit window", last_win, BASE * 8);
    chk_eq("R7 12-bit of 0xE71", temp_o, 12'hE71);
    write_cfg(1'b0, 2'b01, 1'b0);
    model_raw = 12'hE73;
    wait_done();
    chk_eq("R7 12-bit of 0xE73", temp_o, 12'hE73);
    wait_done();
    chk_eq("R6 10-bit window", last_win, BASE * 2);
    chk_eq("R7 10-bit of 0xE73", temp_o, 12'hE70);
    write_cfg(1'b0, 2'b10, 1'b0);
    model_raw = 12'h0FF;
    wait_done();
    chk_eq("R7 10-bit of 0x0FF", temp_o, 12'h0FC);
    wait_done();
    chk_eq("R6 11-bit window", last_win, BASE * 4);
    chk_eq("R7 11-bit of 0x0FF", temp_o, 12'h0FE);
  endtask

  task automatic t_halt();
    int s;
    write_cfg(1'b0, 2'b10, 1'b1);
    chk_eq("R2 busy while draining", busy_o, 1);
    wait_done();
    chk_eq("R2 drained window", last_win, BASE * 4);
    chk_eq("R2 idle at completion", {busy_o, adc_start_o}, 0);
    s = start_cnt;
    tick(100);
    chk_eq("R2 no start while halted", start_cnt, s);
    chk_eq("R5 readback halt/res", cfg_rdata_o, 4'b0101);
  endtask

  task automatic t_oneshot();
    int s;
    s = start_cnt;
    model_raw = 12'h7FF;
    write_cfg(1'b1, 2'b11, 1'b1);
    chk_eq("R5 single reads 0", cfg_rdata_o, 4'b0111);
    wait_done();
    chk_eq("R3 one result", temp_o, 12'h7FF);
    chk_eq("R3 back to idle", busy_o, 0);
    tick(100);
    chk_eq("R3 exactly one start", start_cnt, s + 1);
  endtask

  task automatic t_ignore();
    int s;
    write_cfg(1'b0, 2'b00, 1'b0);
    wait_done();
    s = start_cnt;
    write_cfg(1'b0, 2'b00, 1'b1);
    write_cfg(1'b1, 2'b00, 1'b1);
    chk_eq("R4 still busy", busy_o, 1);
    wait_done();
    tick(100);
    chk_eq("R4 request during drain ignored", start_cnt, s);
  endtask

  task automatic t_late();
    model_lat = 20;
    model_raw = 12'h004;
    write_cfg(1'b1, 2'b00, 1'b1);
    wait_done();
    chk_eq("R10 late sample stretches", last_win, 22);
    chk_eq("R7 9-bit of 0x004", temp_o, 12'h000);
    model_lat = 3;
  endtask

  task automatic t_stray();
    int d;
    tick(5);
    d = done_cnt;
    inj_raw = 12'h555;
    inj = 1'b1;
    tick(20);
    chk_eq("R10 idle strobe no completion", done_cnt, d);
    chk_eq("R10 idle strobe temp kept", temp_o, 12'h000);
    chk_eq("R9 temp changed only on done", glitch, 0);
  endtask

  initial begin
    t_reset();
    t_continuous();
    t_resolution();
    t_halt();
    t_oneshot();
    t_ignore();
    t_late();
    t_stray();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule